// File: doc/BRIEF.md
# Saturating Left Shifter with Status Flags

This unit sits in a DSP datapath and shifts an operand left by a count, at one of three widths: a 16-bit half word, a 32-bit word or a 40-bit accumulator. A fourth mode treats the low 32 bits of the operand as two independent 16-bit halves. Both halves are shifted by the same count, and the two results are packed back into one word. The unit watches the bits pushed out above the selected width to decide whether the shift overflowed. When saturation is enabled, an overflowing or sign-flipping shift is clamped to the largest positive or largest negative value of that width.

The unit returns negative, zero and overflow flags, plus a sticky overflow flag. The sticky flag stays set until a dedicated clear input removes it. Saturation and overflow reporting are enabled separately. The accumulator width never saturates and leaves both overflow flags untouched.

An operation is presented with `valid_i` for one cycle. The result and flags appear on the registered outputs one clock later, together with `valid_o`. When `valid_i` is low, the outputs hold their last values.

Top module: `sat_lshift_unit`

## Requirements
- R1: The effective shift count is the smaller of `count_i` and the selected width. For example, a count of 63 at the 16-bit width gives the same result and flags as a count of 16.
- R2: Overflow is detected unless the bits shifted out above the width are either all zero, or all one while the result's top bit is one. A shift by zero never overflows.
- R3: At the 16-bit width (`size_i`=0, `dual_i`=0) with `sat_en_i`=1, the result is 0x7FFF (non-negative input) or 0x8000 (negative input) whenever overflow is detected or the result sign differs from the input sign. A saturated result counts as overflow.
- R4: At the 32-bit width (`size_i`=1) with `sat_en_i`=1, the same rule clamps to 0x7FFFFFFF or 0x80000000. A non-zero, non-negative input whose result is zero also clamps. A saturated result counts as overflow.
- R5: `neg_o` is the top bit of the result at the selected width, and `zero_o` is set when the result at that width is zero. Result bits above the selected width are zero, and operand bits above it are ignored.
- R6: On an operation that reports overflow (any width except 40), `ovf_o` becomes `ovf_en_i` AND the overflow condition. With `ovf_en_i`=0 it is therefore 0.
- R7: `sticky_o` is set whenever `ovf_o` is set by an operation. No operation ever clears it.
- R8: `sticky_clr_i` clears `sticky_o` on the next edge. The clear wins over a set in the same cycle.
- R9: At the 40-bit width (`size_i`=2 or 3, `dual_i`=0), the result is the operand shifted and truncated to 40 bits with no saturation. `ovf_o` and `sticky_o` keep their previous values.
- R10: With `dual_i`=1, `size_i` is ignored. Bits 15:0 and 31:16 are shifted and saturated as two 16-bit values, and the results are packed with the upper half in bits 31:16. The negative, zero and overflow flags are the OR of the two halves.
- R11: The result and flags register one edge after `valid_i`, and `valid_o` is high in exactly that cycle. Without `valid_i`, the result and flags hold.
- R12: Synchronous active-high reset clears the result, all flags and `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| opnd_i | input | 40 | Operand, low-aligned to the selected width |
| count_i | input | 6 | Left shift count |
| size_i | input | 2 | Width select: 0=16, 1=32, 2 or 3=40 |
| dual_i | input | 1 | Two packed 16-bit halves mode |
| sat_en_i | input | 1 | Saturation enable |
| ovf_en_i | input | 1 | Overflow report enable |
| sticky_clr_i | input | 1 | Clear for the sticky overflow flag |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 40 | Shifted result, zero above the selected width |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Overflow flag |
| sticky_o | output | 1 | Sticky overflow flag |

## Verification
Two functions can act in the same cycle: an overflowing operation that tries to set the sticky flag, and the sticky clear. The bench provokes the collision directly with an overflowing shift and `sticky_clr_i` high together. It also raises the clear at random during the random run. It judges the result by expecting `ovf_o` high and `sticky_o` low on the following cycle. A second collision, saturation together with a disabled overflow report, is judged by expecting a clamped result with `ovf_o` low.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  typedef enum logic [1:0] {
    SZ_HALF = 2'd0,
    SZ_WORD = 2'd1,
    SZ_ACC  = 2'd2,
    SZ_ACC2 = 2'd3
  } size_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic touch;
  } flags_t;
endpackage

// File: rtl/lsh_lane.sv
module lsh_lane #(
  parameter int W         = 16,
  parameter int CNT_W     = 6,
  parameter bit CAN_SAT   = 1'b1,
  parameter bit ZERO_RULE = 1'b0
) (
  input  logic [W-1:0]     val_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             sat_en_i,
  output logic [W-1:0]     res_o,
  output logic             vcond_o,
  output logic             sat_hit_o
);
  localparam int CW = $clog2(W + 1);

  function automatic logic [CW-1:0] clamp_cnt(input logic [CNT_W-1:0] c);
    return (int'(c) > W) ? CW'(W) : CW'(c);
  endfunction

  function automatic logic spill_ovf(input logic [W-1:0] spill,
                                     input logic [W-1:0] lowmask,
                                     input logic top);
    return !((spill == '0) || ((spill == lowmask) && top));
  endfunction

  function automatic logic [W-1:0] sat_value(input logic negative);
    return negative ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
  endfunction

  logic [CW-1:0]  cc;
  logic [2*W-1:0] wide;
  logic [W-1:0]   spill;
  logic [W-1:0]   shifted;
  logic [W-1:0]   lowmask;
  logic           raw_ovf;

  always_comb begin
    cc      = clamp_cnt(cnt_i);
    wide    = {{W{1'b0}}, val_i} << cc;
    spill   = wide[2*W-1:W];
    shifted = wide[W-1:0];
    lowmask = ~({W{1'b1}} << cc);
    raw_ovf = spill_ovf(spill, lowmask, shifted[W-1]);
  end

  generate
    if (CAN_SAT) begin : g_sat
      logic trig;
      always_comb begin
        trig = sat_en_i && (raw_ovf || (val_i[W-1] != shifted[W-1]) ||
               (ZERO_RULE && !val_i[W-1] && (val_i != '0) && (shifted == '0)));
        res_o     = trig ? sat_value(val_i[W-1]) : shifted;
        vcond_o   = raw_ovf | trig;
        sat_hit_o = trig;
      end
    end else begin : g_nosat
      always_comb begin
        res_o     = shifted;
        vcond_o   = raw_ovf;
        sat_hit_o = 1'b0 & sat_en_i;
      end
    end
  endgenerate
endmodule

// File: rtl/lsh_merge.sv
module lsh_merge
  import lsh_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int WORD_W = 32,
  parameter int ACC_W  = 40
) (
  input  logic              dual_i,
  input  logic [1:0]        size_i,
  input  logic [HALF_W-1:0] h0_res_i,
  input  logic              h0_v_i,
  input  logic              h0_sat_i,
  input  logic [HALF_W-1:0] h1_res_i,
  input  logic              h1_v_i,
  input  logic              h1_sat_i,
  input  logic [WORD_W-1:0] w_res_i,
  input  logic              w_v_i,
  input  logic              w_sat_i,
  input  logic [ACC_W-1:0]  a_res_i,
  input  logic              a_v_i,
  input  logic              a_sat_i,
  output logic [ACC_W-1:0]  res_o,
  output flags_t            flags_o,
  output logic              sel_sat_o
);
  localparam int PAD = ACC_W - 2*HALF_W;

  function automatic logic is_zero_half(input logic [HALF_W-1:0] v);
    return v == '0;
  endfunction

  always_comb begin
    res_o     = '0;
    flags_o   = '0;
    sel_sat_o = 1'b0;
    if (dual_i) begin
      res_o         = {{PAD{1'b0}}, h1_res_i, h0_res_i};
      flags_o.neg   = h1_res_i[HALF_W-1] | h0_res_i[HALF_W-1];
      flags_o.zero  = is_zero_half(h1_res_i) | is_zero_half(h0_res_i);
      flags_o.ovf   = h1_v_i | h0_v_i;
      flags_o.touch = 1'b1;
      sel_sat_o     = h1_sat_i | h0_sat_i;
    end else begin
      case (size_e'(size_i))
        SZ_HALF: begin
          res_o         = ACC_W'(h0_res_i);
          flags_o.neg   = h0_res_i[HALF_W-1];
          flags_o.zero  = is_zero_half(h0_res_i);
          flags_o.ovf   = h0_v_i;
          flags_o.touch = 1'b1;
          sel_sat_o     = h0_sat_i;
        end
        SZ_WORD: begin
          res_o         = ACC_W'(w_res_i);
          flags_o.neg   = w_res_i[WORD_W-1];
          flags_o.zero  = (w_res_i == '0);
          flags_o.ovf   = w_v_i;
          flags_o.touch = 1'b1;
          sel_sat_o     = w_sat_i;
        end
        default: begin
          res_o         = a_res_i;
          flags_o.neg   = a_res_i[ACC_W-1];
          flags_o.zero  = (a_res_i == '0);
          flags_o.ovf   = a_v_i;
          flags_o.touch = 1'b0;
          sel_sat_o     = a_sat_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsh_regs.sv
module lsh_regs
  import lsh_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             valid_i,
  input  logic             ovf_en_i,
  input  logic             sticky_clr_i,
  input  logic [ACC_W-1:0] res_i,
  input  flags_t           flags_i,
  output logic             valid_o,
  output logic [ACC_W-1:0] result_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             sticky_o
);
  logic ovf_upd;
  logic ovf_next;

  always_comb begin
    ovf_upd  = valid_i & flags_i.touch;
    ovf_next = ovf_en_i & flags_i.ovf;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      neg_o    <= 1'b0;
      zero_o   <= 1'b0;
      ovf_o    <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_i;
        neg_o    <= flags_i.neg;
        zero_o   <= flags_i.zero;
      end
      if (ovf_upd) ovf_o <= ovf_next;
      if (sticky_clr_i)            sticky_o <= 1'b0;
      else if (ovf_upd && ovf_next) sticky_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sat_lshift_unit.sv
module sat_lshift_unit
  import lsh_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int WORD_W = 32,
  parameter int ACC_W  = 40,
  parameter int CNT_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             valid_i,
  input  logic [ACC_W-1:0] opnd_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       size_i,
  input  logic             dual_i,
  input  logic             sat_en_i,
  input  logic             ovf_en_i,
  input  logic             sticky_clr_i,
  output logic             valid_o,
  output logic [ACC_W-1:0] result_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             sticky_o
);
  localparam int NHALF = 2;

  logic [HALF_W-1:0] h_res [NHALF];
  logic              h_v   [NHALF];
  logic              h_sat [NHALF];
  logic [WORD_W-1:0] w_res;
  logic              w_v, w_sat;
  logic [ACC_W-1:0]  a_res;
  logic              a_v, a_sat;
  logic [ACC_W-1:0]  res_n;
  flags_t            flags_n;

  // Named internal events for the checker
  logic sel_sat_w;
  logic ovf_touch_w;
  logic ovf_event_w;
  logic sat_half_w;

  generate
    for (genvar g = 0; g < NHALF; g++) begin : g_half
      lsh_lane #(.W(HALF_W), .CNT_W(CNT_W), .CAN_SAT(1'b1), .ZERO_RULE(1'b0)) u_half (
        .val_i    (opnd_i[g*HALF_W +: HALF_W]),
        .cnt_i    (count_i),
        .sat_en_i (sat_en_i),
        .res_o    (h_res[g]),
        .vcond_o  (h_v[g]),
        .sat_hit_o(h_sat[g])
      );
    end
  endgenerate

  lsh_lane #(.W(WORD_W), .CNT_W(CNT_W), .CAN_SAT(1'b1), .ZERO_RULE(1'b1)) u_word (
    .val_i    (opnd_i[WORD_W-1:0]),
    .cnt_i    (count_i),
    .sat_en_i (sat_en_i),
    .res_o    (w_res),
    .vcond_o  (w_v),
    .sat_hit_o(w_sat)
  );

  lsh_lane #(.W(ACC_W), .CNT_W(CNT_W), .CAN_SAT(1'b0), .ZERO_RULE(1'b0)) u_acc (
    .val_i    (opnd_i),
    .cnt_i    (count_i),
    .sat_en_i (sat_en_i),
    .res_o    (a_res),
    .vcond_o  (a_v),
    .sat_hit_o(a_sat)
  );

  lsh_merge #(.HALF_W(HALF_W), .WORD_W(WORD_W), .ACC_W(ACC_W)) u_merge (
    .dual_i   (dual_i),
    .size_i   (size_i),
    .h0_res_i (h_res[0]),
    .h0_v_i   (h_v[0]),
    .h0_sat_i (h_sat[0]),
    .h1_res_i (h_res[1]),
    .h1_v_i   (h_v[1]),
    .h1_sat_i (h_sat[1]),
    .w_res_i  (w_res),
    .w_v_i    (w_v),
    .w_sat_i  (w_sat),
    .a_res_i  (a_res),
    .a_v_i    (a_v),
    .a_sat_i  (a_sat),
    .res_o    (res_n),
    .flags_o  (flags_n),
    .sel_sat_o(sel_sat_w)
  );

  assign ovf_touch_w = flags_n.touch;
  assign ovf_event_w = valid_i & flags_n.touch & ovf_en_i & flags_n.ovf;
  assign sat_half_w  = h_sat[0] & (dual_i | (size_i == SZ_HALF));

  lsh_regs #(.ACC_W(ACC_W)) u_regs (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .valid_i     (valid_i),
    .ovf_en_i    (ovf_en_i),
    .sticky_clr_i(sticky_clr_i),
    .res_i       (res_n),
    .flags_i     (flags_n),
    .valid_o     (valid_o),
    .result_o    (result_o),
    .neg_o       (neg_o),
    .zero_o      (zero_o),
    .ovf_o       (ovf_o),
    .sticky_o    (sticky_o)
  );
endmodule

// File: rtl/lsh_checker.sv
module lsh_checker #(
  parameter int HALF_W = 16
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              valid_i,
  input logic              ovf_en_i,
  input logic              sticky_clr_i,
  input logic              valid_o,
  input logic              ovf_o,
  input logic              sticky_o,
  input logic [HALF_W-1:0] res_lo,
  input logic              sel_sat_w,
  input logic              ovf_touch_w,
  input logic              ovf_event_w,
  input logic              sat_half_w
);
  localparam logic [HALF_W-1:0] POS_MAX = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] NEG_MAX = {1'b1, {(HALF_W-1){1'b0}}};

  a_r11_valid_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i |=> valid_o);
  a_r11_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_i |=> !valid_o);
  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    sticky_clr_i |=> !sticky_o);
  a_r7_no_self_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    (sticky_o && !sticky_clr_i) |=> sticky_o);
  a_r7_sticky_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    (ovf_event_w && !sticky_clr_i) |=> (sticky_o && ovf_o));
  a_r9_acc_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && !ovf_touch_w) |=> $stable(ovf_o));
  a_r6_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && ovf_touch_w && !ovf_en_i) |=> !ovf_o);
  a_r4_sat_is_ovf: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && sel_sat_w && ovf_en_i) |=> ovf_o);
  a_r3_sat_value: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && sat_half_w) |=> ((res_lo == POS_MAX) || (res_lo == NEG_MAX)));
endmodule

bind sat_lshift_unit lsh_checker #(.HALF_W(HALF_W)) u_lsh_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .valid_i     (valid_i),
  .ovf_en_i    (ovf_en_i),
  .sticky_clr_i(sticky_clr_i),
  .valid_o     (valid_o),
  .ovf_o       (ovf_o),
  .sticky_o    (sticky_o),
  .res_lo      (result_o[HALF_W-1:0]),
  .sel_sat_w   (sel_sat_w),
  .ovf_touch_w (ovf_touch_w),
  .ovf_event_w (ovf_event_w),
  .sat_half_w  (sat_half_w)
);

// File: tb/test_sat_lshift_unit.sv
module test_sat_lshift_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i, dual_i, sat_en_i, ovf_en_i, sticky_clr_i;
  logic [39:0] opnd_i;
  logic [5:0]  count_i;
  logic [1:0]  size_i;
  logic        valid_o, neg_o, zero_o, ovf_o, sticky_o;
  logic [39:0] result_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  bit e_ovf  = 1'b0;
  bit e_st   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_lshift_unit i_sat_lshift_unit (
    .clk_i(clk), .rst_i(rst), .valid_i(valid_i), .opnd_i(opnd_i),
    .count_i(count_i), .size_i(size_i), .dual_i(dual_i), .sat_en_i(sat_en_i),
    .ovf_en_i(ovf_en_i), .sticky_clr_i(sticky_clr_i), .valid_o(valid_o),
    .result_o(result_o), .neg_o(neg_o), .zero_o(zero_o), .ovf_o(ovf_o),
    .sticky_o(sticky_o)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Reference: one lane of width w
  function automatic void mdl_lane(input logic [63:0] v_in, input int w, input int cnt,
                                   input bit sat, input bit zrule,
                                   output logic [63:0] r, output bit vc);
    logic [63:0]  msk, val, out, spill, ones;
    logic [127:0] wide;
    int cc;
    bit sgn, top, trig;
    msk   = (64'd1 << w) - 64'd1;
    val   = v_in & msk;
    cc    = (cnt > w) ? w : cnt;
    wide  = {64'd0, val} << cc;
    out   = wide[63:0] & msk;
    spill = 64'(wide >> w);
    ones  = (64'd1 << cc) - 64'd1;
    sgn   = val[w-1];
    top   = out[w-1];
    vc    = !((spill == 64'd0) || ((spill == ones) && top));
    r     = out;
    if (sat && w != 40) begin
      trig = vc || (sgn != top) || (zrule && !sgn && val != 64'd0 && out == 64'd0);
      if (trig) begin
        r  = sgn ? (64'd1 << (w-1)) : ((64'd1 << (w-1)) - 64'd1);
        vc = 1'b1;
      end
    end
  endfunction

  function automatic void mdl_op(input logic [39:0] op, input int cnt, input int sz,
                                 input bit dual, input bit sat,
                                 output logic [39:0] r, output bit n, output bit z,
                                 output bit v, output bit touch);
    logic [63:0] r0, r1;
    bit v0, v1;
    if (dual) begin
      mdl_lane(64'(op[15:0]), 16, cnt, sat, 1'b0, r0, v0);
      mdl_lane(64'(op[31:16]), 16, cnt, sat, 1'b0, r1, v1);
      r = {8'd0, r1[15:0], r0[15:0]};
      n = r0[15] | r1[15];
      z = (r0 == 0) | (r1 == 0);
      v = v0 | v1;
      touch = 1'b1;
    end else begin
      int w;
      w = (sz == 0) ? 16 : (sz == 1) ? 32 : 40;
      mdl_lane(64'(op), w, cnt, sat, (w == 32), r0, v0);
      r = r0[39:0];
      n = r0[w-1];
      z = (r0 == 0);
      v = v0;
      touch = (w != 40);
    end
  endfunction

  task automatic run_op(input string tag, input logic [39:0] op, input int cnt,
                        input int sz, input bit dual, input bit sat, input bit oen,
                        input bit clr);
    logic [39:0] er;
    bit en, ez, ev, et;
    mdl_op(op, cnt, sz, dual, sat, er, en, ez, ev, et);
    if (et) e_ovf = oen & ev;
    if (clr) e_st = 1'b0;
    else if (et && oen && ev) e_st = 1'b1;
    @(negedge clk);
    opnd_i = op; count_i = 6'(cnt); size_i = 2'(sz); dual_i = dual;
    sat_en_i = sat; ovf_en_i = oen; sticky_clr_i = clr; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0; sticky_clr_i = 1'b0;
    chk({tag, " result"}, 64'(result_o), 64'(er));
    chk({tag, " neg"}, 64'(neg_o), 64'(en));
    chk({tag, " zero"}, 64'(zero_o), 64'(ez));
    chk({tag, " ovf"}, 64'(ovf_o), 64'(e_ovf));
    chk({tag, " sticky"}, 64'(sticky_o), 64'(e_st));
    chk({tag, " valid R11"}, 64'(valid_o), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [39:0] r_a, r_b;
    void'($urandom(32'd20240607));
    rst = 1'b1; valid_i = 0; opnd_i = '0; count_i = '0; size_i = '0;
    dual_i = 0; sat_en_i = 0; ovf_en_i = 0; sticky_clr_i = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 reset result", 64'(result_o), 64'd0);
    chk("R12 reset flags", {60'd0, neg_o, zero_o, ovf_o, sticky_o}, 64'd0);
    chk("R12 reset valid", 64'(valid_o), 64'd0);

    // R1 count clamp
    run_op("R1 cnt63", 40'h3, 63, 0, 0, 0, 1, 0);
    r_a = result_o;
    run_op("R1 cnt16", 40'h3, 16, 0, 0, 0, 1, 0);
    r_b = result_o;
    chk("R1 clamp equal", 64'(r_a), 64'(r_b));

    // R2 overflow rule
    run_op("R2 ones-top", 40'hC000, 1, 0, 0, 0, 1, 1);
    chk("R2 no ovf when spill ones and top one", 64'(ovf_o), 64'd0);
    run_op("R2 zero-spill", 40'h4000, 1, 0, 0, 0, 1, 0);
    chk("R2 no ovf when spill zero", 64'(ovf_o), 64'd0);
    run_op("R2 ones-top0", 40'h8000, 1, 0, 0, 0, 1, 0);
    chk("R2 ovf", 64'(ovf_o), 64'd1);
    run_op("R2 cnt0", 40'hFFFF, 0, 0, 0, 0, 1, 1);

    // R3 16-bit saturation
    run_op("R3 pos", 40'h4000, 1, 0, 0, 1, 1, 0);
    chk("R3 pos clamp", 64'(result_o), 64'h7FFF);
    run_op("R3 neg", 40'h9000, 2, 0, 0, 1, 1, 0);
    chk("R3 neg clamp", 64'(result_o), 64'h8000);
    run_op("R3 upper ignored", 40'hAB_CDEF_0001, 3, 0, 0, 1, 1, 1);

    // R4 32-bit saturation
    run_op("R4 pos", 40'h4000_0000, 2, 1, 0, 1, 1, 0);
    chk("R4 pos clamp", 64'(result_o), 64'h7FFF_FFFF);
    run_op("R4 neg", 40'h8000_0001, 1, 1, 0, 1, 1, 0);
    chk("R4 neg clamp", 64'(result_o), 64'h8000_0000);
    run_op("R4 zero rule", 40'h0001_0000, 16, 1, 0, 1, 1, 1);
    chk("R4 zero rule clamp", 64'(result_o), 64'h7FFF_FFFF);

    // R5 flags
    run_op("R5 neg", 40'h1, 31, 1, 0, 0, 1, 1);
    chk("R5 neg flag", 64'(neg_o), 64'd1);
    run_op("R5 zero", 40'h0, 5, 1, 0, 1, 1, 0);
    chk("R5 zero flag", 64'(zero_o), 64'd1);

    // R6 report disabled, saturation still active
    run_op("R6 sat no report", 40'h4000, 1, 0, 0, 1, 0, 0);
    chk("R6 ovf low", 64'(ovf_o), 64'd0);

    // R7 sticky
    run_op("R7 set", 40'h8000, 3, 0, 0, 0, 1, 0);
    run_op("R7 hold", 40'h1, 1, 0, 0, 0, 1, 0);
    chk("R7 sticky kept", 64'(sticky_o), 64'd1);

    // R8 clear vs set collision
    run_op("R8 collide", 40'h8000, 1, 0, 0, 0, 1, 1);
    chk("R8 ovf set", 64'(ovf_o), 64'd1);
    chk("R8 sticky cleared", 64'(sticky_o), 64'd0);

    // R9 accumulator width
    run_op("R9 prep", 40'h8000, 1, 0, 0, 0, 1, 0);
    run_op("R9 acc", 40'h80_0000_0001, 1, 2, 0, 1, 1, 0);
    chk("R9 no sat", 64'(result_o), 64'h2);
    chk("R9 ovf kept", 64'(ovf_o), 64'd1);
    run_op("R9 acc size3", 40'hFF_FFFF_FFFF, 8, 3, 0, 1, 0, 1);

    // R10 dual halves
    run_op("R10 dual", 40'h4000_0001, 1, 0, 1, 1, 1, 0);
    chk("R10 packed", 64'(result_o), 64'h7FFF_0002);
    run_op("R10 dual size ignored", 40'hFF_8000_0000, 1, 2, 1, 0, 1, 1);
    chk("R10 zero OR", 64'(zero_o), 64'd1);

    // R11 hold without valid
    r_a = result_o;
    @(negedge clk);
    opnd_i = 40'h12345; count_i = 6'd4; size_i = 2'd1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 hold result", 64'(result_o), 64'(r_a));
    chk("R11 valid low", 64'(valid_o), 64'd0);

    // Random mix (R2 R3 R4 R5 R6 R7 R8 R9 R10)
    for (int i = 0; i < 500; i++) begin
      logic [39:0] op;
      int cnt;
      op = {8'($urandom), 32'($urandom)};
      case ($urandom % 4)
        0: op = op & 40'h3;
        1: op = op | 40'hFF_FFFF_FF00;
        default: ;
      endcase
      cnt = ($urandom % 4 == 0) ? int'($urandom % 64) : int'($urandom % 9);
      run_op("R2-rand", op, cnt, int'($urandom % 4), ($urandom % 4 == 0),
             bit'($urandom % 2), bit'($urandom % 4 != 0), ($urandom % 8 == 0));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule